// File: doc/BRIEF.md
# I2C Ten-Bit Address Slave

This block is the bus side of an I2C target that answers to a 10-bit address. It watches the SCL and SDA line levels through two-flop synchronizers, finds START, repeated START and STOP, and walks through the two-byte address sequence: a header byte that carries the upper two address bits, then a byte that carries the lower eight. A single compare register serves both bytes. After each matched write-direction address byte the block holds SCL low and raises an update flag. The host then reloads the compare register: the low byte after the header, and the header form again after the low byte. Writing the register frees the clock.

Once the full address has matched, the master may issue a repeated START and resend the header with the read bit set. The block then acknowledges and enters transmit mode without a second low byte. In transmit mode it stretches the clock until the host has loaded the data buffer and set the clock-release bit. It shifts the byte out MSB first, and after a master ACK it stretches again for the next byte. Both bus outputs are pull-low enables for open-drain pads.

Top module: `i2c10_slave`

## Requirements
- R1: A header byte is bits 7:3 = 11110, bit 2 = A9, bit 1 = A8, bit 0 = R/W (1 = read). A write header is acknowledged (SDA pulled low on the 9th clock) only when the prefix matches and bits 2:1 equal bits 2:1 of the compare register.
- R2: The byte that follows an accepted write header is acknowledged only when it equals all eight bits of the compare register.
- R3: At the end of the 9th clock of each accepted write-direction address byte, the update flag is set and SCL is pulled low. The flag clears and SCL is released only on a host write of the compare register.
- R4: Once both address bytes are accepted, every further written byte is acknowledged and copied to the data buffer, and the clock is not stretched.
- R5: A read header (bit 0 = 1) that follows a full address match made since the last STOP is acknowledged, and it puts the block in transmit mode at once. A read header with no such match is not acknowledged.
- R6: On entry to transmit mode the clock-release bit clears and SCL is held low until the host sets the bit. The buffer byte is then sent MSB first.
- R7: Every accepted received byte, address bytes included, is copied into the buffer and sets buffer-full. A host read clears buffer-full. In transmit mode a host buffer write sets buffer-full, and the end of the 8th bit shifted out clears it.
- R8: The interrupt flag is set at the end of the 9th clock of every accepted byte and stays set until the host clears it.
- R9: A STOP ends the transaction, returns the block to idle and forgets the address match.
- R10: After a transmitted byte, a master ACK on the 9th clock clears the clock-release bit and stretches SCL again. A NACK releases both lines and the block ignores the bus until the next START or STOP.
- R11: A header or low address byte that does not match is not acknowledged, and all later bytes are ignored, left without ACK, until the next START.
- R12: After reset both pull enables are off, the interrupt, buffer-full and update flags are clear, and the clock-release bit is 1.
- R13: The SDA pull enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_pull_o | output | 1 | Pull SCL low (open-drain enable) |
| sda_pull_o | output | 1 | Pull SDA low (open-drain enable) |
| buf_wdata_i | input | 8 | Host data for a buffer write |
| buf_we_i | input | 1 | Host buffer write strobe |
| buf_re_i | input | 1 | Host buffer read strobe |
| buf_rdata_o | output | 8 | Data buffer contents |
| addr_wdata_i | input | 8 | Host data for a compare-register write |
| addr_we_i | input | 1 | Host compare-register write strobe |
| ckp_set_i | input | 1 | Host sets the clock-release bit |
| irq_clr_i | input | 1 | Host clears the interrupt flag |
| irq_o | output | 1 | Interrupt flag |
| bf_o | output | 1 | Buffer-full flag |
| ua_o | output | 1 | Update-address flag |
| ckp_o | output | 1 | Clock-release bit |

## Verification
The bench sweeps every value of A9:A8, flips each prefix bit of the header in turn, and tries a set of low bytes next to the programmed one. A compare that looks at the wrong bits would acknowledge the wrong headers or low bytes. It sends a read header both after a full match and straight after a STOP. A block that keeps the match across STOP, or that accepts a bare read header, would acknowledge the second case. It ends one transmitted byte with ACK and the next with NACK, and checks whether SCL stays held or both lines are freed. On every transmitted bit it also compares SDA at the start and end of the SCL high phase, which catches data that moves on the wrong edge.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 2);
  localparam logic [4:0]  HDR_PREFIX = 5'b11110;

  typedef enum logic [2:0] {
    PH_IDLE, PH_HDR, PH_LOW, PH_RX, PH_TX, PH_SKIP
  } phase_e;
endpackage

// File: rtl/i2c10_sync.sv
module i2c10_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;  // idle bus is high
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/i2c10_cond.sv
module i2c10_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign rise_o  =  scl_i & ~scl_q;
  assign fall_o  = ~scl_i &  scl_q;
  assign start_o =  scl_i &  scl_q &  sda_q & ~sda_i;
  assign stop_o  =  scl_i &  scl_q & ~sda_q &  sda_i;
endmodule

// File: rtl/i2c10_slave.sv
module i2c10_slave
  import i2c10_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull_o,
  output logic              sda_pull_o,
  input  logic [BYTE_W-1:0] buf_wdata_i,
  input  logic              buf_we_i,
  input  logic              buf_re_i,
  output logic [BYTE_W-1:0] buf_rdata_o,
  input  logic [BYTE_W-1:0] addr_wdata_i,
  input  logic              addr_we_i,
  input  logic              ckp_set_i,
  input  logic              irq_clr_i,
  output logic              irq_o,
  output logic              bf_o,
  output logic              ua_o,
  output logic              ckp_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

  logic [1:0] raw_w, syn_w;
  logic       scl_s, sda_s;
  logic       start_w, stop_w, rise_w, fall_w;

  assign raw_w = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    i2c10_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw_w[g]),
      .q_o   (syn_w[g])
    );
  end

  assign scl_s = syn_w[1];
  assign sda_s = syn_w[0];

  i2c10_cond u_cond (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (scl_s),
    .sda_i  (sda_s),
    .start_o(start_w),
    .stop_o (stop_w),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  phase_e            ph_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] rx_sr_q, tx_sr_q, buf_q, addr_q;
  logic ack_q, hit_q, rw_q, mack_q, tx_drv_q, matched_q;
  logic irq_q, bf_q, ua_q, ckp_q;

  logic active_w, byte_end_w, ack_end_w, accept_w, rx_load_w, hdr_ok_w;

  assign active_w   = (ph_q != PH_IDLE) && (ph_q != PH_SKIP);
  assign byte_end_w = active_w && fall_w && (cnt_q == LAST_BIT);
  assign ack_end_w  = active_w && fall_w && (cnt_q == ACK_BIT);
  assign hdr_ok_w   = (rx_sr_q[7:3] == HDR_PREFIX) && (rx_sr_q[2:1] == addr_q[2:1]);

  always_comb begin
    unique case (ph_q)
      PH_HDR:  accept_w = hdr_ok_w && (!rx_sr_q[0] || matched_q);
      PH_LOW:  accept_w = (rx_sr_q == addr_q);
      PH_RX:   accept_w = 1'b1;
      default: accept_w = 1'b0;
    endcase
  end

  assign rx_load_w = byte_end_w && accept_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q      <= PH_IDLE;
      cnt_q     <= '0;
      rx_sr_q   <= '0;
      tx_sr_q   <= '0;
      buf_q     <= '0;
      addr_q    <= '0;
      ack_q     <= 1'b0;
      hit_q     <= 1'b0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      tx_drv_q  <= 1'b0;
      matched_q <= 1'b0;
      irq_q     <= 1'b0;
      bf_q      <= 1'b0;
      ua_q      <= 1'b0;
      ckp_q     <= 1'b1;
    end else begin
      // host side; bus events below take priority
      if (buf_re_i)  bf_q <= 1'b0;
      if (buf_we_i) begin
        buf_q <= buf_wdata_i;
        bf_q  <= 1'b1;
        if (ph_q == PH_TX && !ckp_q) tx_sr_q <= buf_wdata_i;
      end
      if (addr_we_i) begin
        addr_q <= addr_wdata_i;
        ua_q   <= 1'b0;
      end
      if (ckp_set_i) ckp_q <= 1'b1;
      if (irq_clr_i) irq_q <= 1'b0;

      if (start_w) begin
        ph_q     <= PH_HDR;
        cnt_q    <= '0;
        ack_q    <= 1'b0;
        hit_q    <= 1'b0;
        tx_drv_q <= 1'b0;
      end else if (stop_w) begin
        ph_q      <= PH_IDLE;
        cnt_q     <= '0;
        ack_q     <= 1'b0;
        hit_q     <= 1'b0;
        tx_drv_q  <= 1'b0;
        matched_q <= 1'b0;
      end else if (active_w) begin
        if (rise_w) begin
          if (cnt_q < LAST_BIT) rx_sr_q <= {rx_sr_q[BYTE_W-2:0], sda_s};
          else                  mack_q  <= ~sda_s;
          cnt_q <= cnt_q + 1'b1;
        end

        if (fall_w && ph_q == PH_TX && cnt_q != '0 && cnt_q < LAST_BIT)
          tx_sr_q <= {tx_sr_q[BYTE_W-2:0], 1'b0};

        if (byte_end_w) begin
          if (ph_q == PH_TX) begin
            tx_drv_q <= 1'b0;
            bf_q     <= 1'b0;
            hit_q    <= 1'b1;
          end else if (accept_w) begin
            ack_q <= 1'b1;
            hit_q <= 1'b1;
            rw_q  <= rx_sr_q[0];
            buf_q <= rx_sr_q;
            bf_q  <= 1'b1;
          end else begin
            ph_q <= PH_SKIP;
          end
        end

        if (ack_end_w) begin
          cnt_q <= '0;
          ack_q <= 1'b0;
          hit_q <= 1'b0;
          if (hit_q) begin
            irq_q <= 1'b1;
            unique case (ph_q)
              PH_HDR: begin
                if (rw_q) begin
                  ph_q     <= PH_TX;
                  tx_drv_q <= 1'b1;
                  ckp_q    <= 1'b0;
                end else begin
                  ph_q <= PH_LOW;
                  ua_q <= 1'b1;
                end
              end
              PH_LOW: begin
                ph_q      <= PH_RX;
                ua_q      <= 1'b1;
                matched_q <= 1'b1;
              end
              PH_TX: begin
                if (mack_q) begin
                  tx_drv_q <= 1'b1;
                  ckp_q    <= 1'b0;
                end else begin
                  ph_q <= PH_SKIP;
                end
              end
              default: ;
            endcase
          end
        end
      end
    end
  end

  assign sda_pull_o  = ack_q | (tx_drv_q & ~tx_sr_q[BYTE_W-1]);
  assign scl_pull_o  = ua_q | ~ckp_q;
  assign buf_rdata_o = buf_q;
  assign irq_o       = irq_q;
  assign bf_o        = bf_q;
  assign ua_o        = ua_q;
  assign ckp_o       = ckp_q;

  p_ack_window_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |-> (cnt_q >= LAST_BIT));

  p_ua_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ua_o) |-> $past(addr_we_i));

  p_bf_source_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bf_o) |-> ($past(buf_we_i) || $past(rx_load_w)));

  p_irq_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o);

  p_stop_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_w |=> (ph_q == PH_IDLE));

  p_sda_scl_low_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s && $past(scl_s)) |-> $stable(sda_pull_o));
endmodule

// File: tb/tb_i2c10_slave.sv
module tb_i2c10_slave;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_pull, sda_pull, scl_line, sda_line;
  logic [7:0] buf_wdata = '0, buf_rdata, addr_wdata = '0;
  logic buf_we = 1'b0, buf_re = 1'b0, addr_we = 1'b0, ckp_set = 1'b0, irq_clr = 1'b0;
  logic irq, bf, ua, ckp;

  assign scl_line = scl_m & ~scl_pull;
  assign sda_line = sda_m & ~sda_pull;

  i2c10_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_pull_o(scl_pull), .sda_pull_o(sda_pull),
    .buf_wdata_i(buf_wdata), .buf_we_i(buf_we), .buf_re_i(buf_re), .buf_rdata_o(buf_rdata),
    .addr_wdata_i(addr_wdata), .addr_we_i(addr_we), .ckp_set_i(ckp_set), .irq_clr_i(irq_clr),
    .irq_o(irq), .bf_o(bf), .ua_o(ua), .ckp_o(ckp)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic scl_high();
    scl_m = 1'b1;
    wait (scl_line === 1'b1);
    @(negedge clk);
    wq();
  endtask

  task automatic bus_start();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wq();
    scl_high();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_high();
    sda_m = 1'b1; wq();
  endtask

  task automatic wr_bit(input logic b);
    sda_m = b; wq();
    scl_high();
    scl_m = 1'b0; wq();
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic acked);
    for (int i = 7; i >= 0; i--) wr_bit(d[i]);
    sda_m = 1'b1; wq();
    scl_high();
    acked = ~sda_line;
    scl_m = 1'b0; wq();
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] d, output logic moved);
    moved = 1'b0;
    for (int i = 0; i < 8; i++) begin
      logic first;
      sda_m = 1'b1; wq();
      scl_m = 1'b1;
      wait (scl_line === 1'b1);
      @(negedge clk);
      first = sda_line;
      wq();
      if (sda_line !== first) moved = 1'b1;
      d = {d[6:0], sda_line};
      scl_m = 1'b0; wq();
    end
    wr_bit(~give_ack);
  endtask

  task automatic h_addr(input logic [7:0] v);
    @(negedge clk); addr_wdata = v; addr_we = 1'b1;
    @(negedge clk); addr_we = 1'b0;
  endtask

  task automatic h_buf_wr(input logic [7:0] v);
    @(negedge clk); buf_wdata = v; buf_we = 1'b1;
    @(negedge clk); buf_we = 1'b0;
  endtask

  task automatic h_buf_rd();
    @(negedge clk); buf_re = 1'b1;
    @(negedge clk); buf_re = 1'b0;
  endtask

  task automatic h_irq_clr();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic h_ckp();
    @(negedge clk); ckp_set = 1'b1;
    @(negedge clk); ckp_set = 1'b0;
  endtask

  localparam logic [1:0] A_HI = 2'b10;
  localparam logic [7:0] A_LO = 8'hA5;
  localparam logic [7:0] HDR_W = {5'b11110, A_HI, 1'b0};
  localparam logic [7:0] HDR_R = {5'b11110, A_HI, 1'b1};

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic ak, moved;
    logic [7:0] got;
    logic [7:0] lows [8];
    lows = '{8'hA5, 8'hA4, 8'h25, 8'hA7, 8'h00, 8'hFF, 8'h5A, 8'hB5};

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 sda_pull", sda_pull, 0);
    chk("R12 scl_pull", scl_pull, 0);
    chk("R12 irq", irq, 0);
    chk("R12 bf", bf, 0);
    chk("R12 ua", ua, 0);
    chk("R12 ckp", ckp, 1);

    h_addr(HDR_W);

    // full write transaction
    bus_start();
    wr_byte(HDR_W, ak);
    chk("R1 header ack", ak, 1);
    chk("R3 ua set", ua, 1);
    chk("R3 scl held", scl_pull, 1);
    chk("R8 irq header", irq, 1);
    chk("R7 bf header", bf, 1);
    chk("R7 buf header", buf_rdata, HDR_W);
    h_buf_rd();
    chk("R7 bf read clear", bf, 0);
    h_irq_clr();
    repeat (4) @(negedge clk);
    chk("R8 irq held until clear", irq, 0);
    chk("R3 still held before write", scl_pull, 1);
    h_addr(A_LO);
    chk("R3 ua cleared", ua, 0);
    chk("R3 scl released", scl_pull, 0);

    wr_byte(A_LO, ak);
    chk("R2 low ack", ak, 1);
    chk("R3 ua set low", ua, 1);
    chk("R3 scl held low", scl_pull, 1);
    h_buf_rd(); h_irq_clr();
    h_addr(HDR_W);
    chk("R3 released low", scl_pull, 0);

    wr_byte(8'h3C, ak);
    chk("R4 data ack", ak, 1);
    chk("R4 no stretch", scl_pull, 0);
    chk("R7 bf data", bf, 1);
    chk("R7 buf data", buf_rdata, 8'h3C);
    chk("R8 irq data", irq, 1);
    h_buf_rd(); h_irq_clr();

    // read direction
    bus_rstart();
    wr_byte(HDR_R, ak);
    chk("R5 read header ack", ak, 1);
    chk("R6 ckp cleared", ckp, 0);
    chk("R6 scl held", scl_pull, 1);
    chk("R5 no ua on read", ua, 0);
    chk("R7 buf read header", buf_rdata, HDR_R);
    h_buf_rd(); h_irq_clr();
    h_buf_wr(8'h5A);
    chk("R7 bf tx write", bf, 1);
    chk("R6 D7 on sda", sda_pull, 1);
    h_ckp();
    chk("R6 ckp set", ckp, 1);
    rd_byte(1'b1, got, moved);
    chk("R6 tx byte", got, 8'h5A);
    chk("R13 sda stable first", moved, 0);
    chk("R7 bf shift clear", bf, 0);
    chk("R8 irq tx", irq, 1);
    chk("R10 ack restretch", ckp, 0);
    chk("R10 scl held", scl_pull, 1);
    h_irq_clr();
    h_buf_wr(8'h69);
    h_ckp();
    rd_byte(1'b0, got, moved);
    chk("R6 tx byte 2", got, 8'h69);
    chk("R13 sda stable second", moved, 0);
    chk("R10 nack scl free", scl_pull, 0);
    chk("R10 nack sda free", sda_pull, 0);
    chk("R10 nack ckp", ckp, 1);
    bus_stop();
    chk("R9 idle sda", sda_pull, 0);
    h_irq_clr();

    // read header straight after STOP
    bus_start();
    wr_byte(HDR_R, ak);
    chk("R9 match forgotten", ak, 0);
    chk("R5 bare read nack", irq, 0);
    bus_stop();

    // header mismatch then ignore
    bus_start();
    wr_byte({5'b11110, 2'b11, 1'b0}, ak);
    chk("R11 header mismatch", ak, 0);
    wr_byte(HDR_W, ak);
    chk("R11 ignored until start", ak, 0);
    chk("R11 no ua", ua, 0);
    chk("R11 no irq", irq, 0);
    bus_stop();

    // A9:A8 sweep
    for (int h = 0; h < 4; h++) begin
      logic [1:0] hv;
      hv = 2'(h);
      bus_start();
      wr_byte({5'b11110, hv, 1'b0}, ak);
      chk($sformatf("R1 hi sweep %0d", h), ak, (hv == A_HI));
      if (ak) begin h_addr(A_LO); h_addr(HDR_W); end
      bus_stop();
    end

    // prefix bit flips
    for (int k = 3; k < 8; k++) begin
      bus_start();
      wr_byte(HDR_W ^ (8'h01 << k), ak);
      chk($sformatf("R1 prefix bit %0d", k), ak, 0);
      bus_stop();
    end

    // low byte sweep
    for (int j = 0; j < 8; j++) begin
      bus_start();
      wr_byte(HDR_W, ak);
      h_addr(A_LO);
      wr_byte(lows[j], ak);
      chk($sformatf("R2 low sweep %0h", lows[j]), ak, (lows[j] == A_LO));
      if (!ak) chk("R11 low mismatch ua", ua, 0);
      h_addr(HDR_W);
      bus_stop();
    end
    h_irq_clr(); h_buf_rd();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule